// File: doc/BRIEF.md
# PPS-Latched Seconds and Ticks Timekeeper

This block keeps absolute time as two words: a seconds count and a ticks count. The ticks count advances by one on every clock. When it reaches a programmable ticks-per-second value, it returns to zero and the seconds count goes up by one. Software programs the block through a write-only settings port. Each setting has a word index relative to a base index.

New time values are staged in holding registers. Writing the ticks holding register arms a one-shot load. The load then happens either on the next clock or on the next chosen edge of a pulse-per-second input. Two pulse inputs exist: a local connector pin and an inter-unit cable pin. Flags pick the pin and the active polarity. Both pins are resynchronised into the clock domain before edge detection. A registered readback pair returns seconds and ticks captured together.

Top module: `tod_timekeeper`

## Requirements
- R1: While reset is asserted and after its release, the readback outputs are zero. After reset the settings hold these defaults: ticks-per-second = DEF_TPS, polarity = falling, source = local, immediate mode off, and no load armed.
- R2: When no load fires, ticks increment each clock. When ticks are at or above ticks-per-second minus one, ticks become 0 and seconds increment in the same cycle.
- R3: A write is decoded at word index REG_BASE+k. k=0 stages seconds, k=1 stages ticks, k=2 holds the flags, k=3 holds immediate mode (data bit 0), and k=4 holds ticks-per-second. Writes to any other index change nothing.
- R4: A write to index REG_BASE+1 arms a load. The armed load is applied once, and then the armed state clears. Later pulse edges do not reload until the block is armed again.
- R5: With immediate mode = 1, an armed load is applied on the clock edge after the arming write. The counter then holds the staged seconds and ticks.
- R6: With immediate mode = 0, an armed load waits for the selected pulse edge. Flags bit 0 = 1 selects the rising edge, and 0 selects the falling edge. An edge of the other polarity does nothing.
- R7: Flags bit 1 = 0 selects the local pin, and 1 selects the cable pin. Edges on the unselected pin are ignored.
- R8: Each pulse pin passes through a two-flop synchroniser. If a pin changes before clock edge A, the load enters the counter at the third edge counted from A. It appears on readback at the fourth edge.
- R9: Readback seconds and ticks are both registered from the counter on the same edge. Each output therefore equals the counter value from one cycle earlier, as a coherent pair.
- R10: The rollover compare is unsigned modulo 2^TICKS_W. With ticks-per-second = 1, seconds increment every clock. With ticks-per-second = 0, ticks wrap only from all-ones. A loaded tick value above the limit wraps on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_stb | input | 1 | Settings write strobe |
| set_addr | input | ADDR_W | Settings word index |
| set_data | input | DATA_W | Settings write data |
| pps_local | input | 1 | Pulse-per-second, local connector |
| pps_cable | input | 1 | Pulse-per-second, inter-unit cable |
| rb_secs | output | SECS_W | Readback seconds |
| rb_ticks | output | TICKS_W | Readback ticks |

## Verification
The bench sets DEF_TPS to 12, which makes rollovers frequent, and keeps the default REG_BASE of 32 in an 8-bit index space. It can therefore write both the index just below the base and the index just above the last setting, and show that neither has any effect. Ticks stay 32 bits wide, so loading a value near all-ones with ticks-per-second set to 0 reaches the full-range wrap within a few cycles. The bench also programs ticks-per-second to 1 and 5 to cover the per-clock seconds step and the wrap of an oversized loaded value.

// File: rtl/tod_pkg.sv
package tod_pkg;
   // word indices relative to REG_BASE
   localparam int IX_SECS  = 0;
   localparam int IX_TICKS = 1;
   localparam int IX_FLAGS = 2;
   localparam int IX_IMM   = 3;
   localparam int IX_TPS   = 4;
   localparam int NUM_IX   = 5;

   localparam int FLAG_EDGE_BIT = 0;
   localparam int FLAG_SRC_BIT  = 1;
   localparam int IMM_BIT       = 0;

   typedef struct packed {
      logic rising;
      logic src_cable;
      logic now;
   } tod_mode_t;
endpackage

// File: rtl/tod_regfile.sv
module tod_regfile
   import tod_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int SECS_W = 32,
   parameter int TICKS_W = 32,
   parameter int unsigned REG_BASE = 32,
   parameter longint unsigned DEF_TPS = 64'd100000000
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               wr_stb,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   output logic [SECS_W-1:0]  ld_secs,
   output logic [TICKS_W-1:0] ld_ticks,
   output logic [TICKS_W-1:0] tps,
   output tod_mode_t          mode,
   output logic               ticks_written
);
   logic [NUM_IX-1:0] hit;

   generate
      if (SECS_W > DATA_W || TICKS_W > DATA_W) begin : g_bad_w
         $error("tod_regfile: counter words wider than data bus");
      end
      for (genvar g = 0; g < NUM_IX; g++) begin : g_dec
         assign hit[g] = wr_stb && (wr_addr == ADDR_W'(REG_BASE + g));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         ld_secs  <= '0;
         ld_ticks <= '0;
         tps      <= TICKS_W'(DEF_TPS);
         mode     <= '0;
      end else begin
         if (hit[IX_SECS])  ld_secs  <= wr_data[SECS_W-1:0];
         if (hit[IX_TICKS]) ld_ticks <= wr_data[TICKS_W-1:0];
         if (hit[IX_TPS])   tps      <= wr_data[TICKS_W-1:0];
         if (hit[IX_FLAGS]) begin
            mode.rising    <= wr_data[FLAG_EDGE_BIT];
            mode.src_cable <= wr_data[FLAG_SRC_BIT];
         end
         if (hit[IX_IMM])   mode.now <= wr_data[IMM_BIT];
      end
   end

   assign ticks_written = hit[IX_TICKS];
endmodule

// File: rtl/tod_pps_edge.sv
module tod_pps_edge #(
   parameter int NSRC = 2,
   parameter int STAGES = 2,
   parameter int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [NSRC-1:0]  pps_in,
   input  logic [SEL_W-1:0] src_sel,
   input  logic             rising,
   output logic             pps_hit
);
   logic [NSRC-1:0] rise_v;
   logic [NSRC-1:0] fall_v;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tod_pps_edge: at least two synchroniser stages required");
      end
      for (genvar s = 0; s < NSRC; s++) begin : g_src
         logic [STAGES-1:0] sh;
         logic              prev;
         always_ff @(posedge clk) begin
            if (rst) begin
               sh   <= '0;
               prev <= 1'b0;
            end else begin
               sh   <= {sh[STAGES-2:0], pps_in[s]};
               prev <= sh[STAGES-1];
            end
         end
         assign rise_v[s] =  sh[STAGES-1] & ~prev;
         assign fall_v[s] = ~sh[STAGES-1] &  prev;
      end
   endgenerate

   assign pps_hit = rising ? rise_v[src_sel] : fall_v[src_sel];
endmodule

// File: rtl/tod_counter.sv
module tod_counter #(
   parameter int SECS_W = 32,
   parameter int TICKS_W = 32
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               arm_req,
   input  logic               immediate,
   input  logic               pps_hit,
   input  logic [SECS_W-1:0]  ld_secs,
   input  logic [TICKS_W-1:0] ld_ticks,
   input  logic [TICKS_W-1:0] tps,
   output logic [SECS_W-1:0]  cnt_secs,
   output logic [TICKS_W-1:0] cnt_ticks,
   output logic               armed,
   output logic               fire
);
   logic [TICKS_W-1:0] limit;
   logic               at_top;

   assign limit  = tps - 1'b1;
   assign at_top = (cnt_ticks >= limit);
   assign fire   = armed & (immediate | pps_hit);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_secs  <= '0;
         cnt_ticks <= '0;
      end else if (fire) begin
         cnt_secs  <= ld_secs;
         cnt_ticks <= ld_ticks;
      end else if (at_top) begin
         cnt_secs  <= cnt_secs + 1'b1;
         cnt_ticks <= '0;
      end else begin
         cnt_ticks <= cnt_ticks + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst)          armed <= 1'b0;
      else if (arm_req) armed <= 1'b1;
      else if (fire)    armed <= 1'b0;
   end
endmodule

// File: rtl/tod_timekeeper.sv
module tod_timekeeper
   import tod_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int SECS_W = 32,
   parameter int TICKS_W = 32,
   parameter int unsigned REG_BASE = 32,
   parameter longint unsigned DEF_TPS = 64'd100000000,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               set_stb,
   input  logic [ADDR_W-1:0]  set_addr,
   input  logic [DATA_W-1:0]  set_data,
   input  logic               pps_local,
   input  logic               pps_cable,
   output logic [SECS_W-1:0]  rb_secs,
   output logic [TICKS_W-1:0] rb_ticks
);
   localparam int NSRC = 2;

   generate
      if (longint'(REG_BASE) + NUM_IX > (64'd1 << ADDR_W)) begin : g_bad_base
         $error("tod_timekeeper: settings window exceeds index space");
      end
   endgenerate

   logic [SECS_W-1:0]  ld_secs;
   logic [TICKS_W-1:0] ld_ticks;
   logic [TICKS_W-1:0] tps;
   tod_mode_t          mode;
   logic               tick_wr;
   logic               pps_hit;
   logic [SECS_W-1:0]  cnt_secs;
   logic [TICKS_W-1:0] cnt_ticks;
   logic               armed;
   logic               fire;

   tod_regfile #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECS_W(SECS_W), .TICKS_W(TICKS_W),
      .REG_BASE(REG_BASE), .DEF_TPS(DEF_TPS)
   ) u_regs (
      .clk(clk), .rst(rst), .wr_stb(set_stb), .wr_addr(set_addr), .wr_data(set_data),
      .ld_secs(ld_secs), .ld_ticks(ld_ticks), .tps(tps), .mode(mode),
      .ticks_written(tick_wr)
   );

   tod_pps_edge #(.NSRC(NSRC), .STAGES(SYNC_STAGES), .SEL_W(1)) u_pps (
      .clk(clk), .rst(rst), .pps_in({pps_cable, pps_local}),
      .src_sel(mode.src_cable), .rising(mode.rising), .pps_hit(pps_hit)
   );

   tod_counter #(.SECS_W(SECS_W), .TICKS_W(TICKS_W)) u_cnt (
      .clk(clk), .rst(rst), .arm_req(tick_wr), .immediate(mode.now), .pps_hit(pps_hit),
      .ld_secs(ld_secs), .ld_ticks(ld_ticks), .tps(tps),
      .cnt_secs(cnt_secs), .cnt_ticks(cnt_ticks), .armed(armed), .fire(fire)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         rb_secs  <= '0;
         rb_ticks <= '0;
      end else begin
         rb_secs  <= cnt_secs;
         rb_ticks <= cnt_ticks;
      end
   end
endmodule

// File: rtl/tod_timekeeper_chk.sv
module tod_timekeeper_chk #(
   parameter int SECS_W = 32,
   parameter int TICKS_W = 32
) (
   input logic               clk,
   input logic               rst,
   input logic               tick_wr,
   input logic               fire,
   input logic               armed,
   input logic [SECS_W-1:0]  cnt_secs,
   input logic [TICKS_W-1:0] cnt_ticks,
   input logic [SECS_W-1:0]  ld_secs,
   input logic [TICKS_W-1:0] ld_ticks,
   input logic [TICKS_W-1:0] tps,
   input logic [SECS_W-1:0]  rb_secs,
   input logic [TICKS_W-1:0] rb_ticks
);
   AST_TICK_STEP: assert property (@(posedge clk) disable iff (rst)
      (!fire && cnt_ticks < TICKS_W'(tps - 1'b1)) |=>
      (cnt_ticks == TICKS_W'($past(cnt_ticks) + 1'b1) && cnt_secs == $past(cnt_secs))); // R2

   AST_TICK_WRAP: assert property (@(posedge clk) disable iff (rst)
      (!fire && cnt_ticks >= TICKS_W'(tps - 1'b1)) |=>
      (cnt_ticks == '0 && cnt_secs == SECS_W'($past(cnt_secs) + 1'b1))); // R2

   AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
      fire |=> (cnt_secs == $past(ld_secs) && cnt_ticks == $past(ld_ticks))); // R4

   AST_ARM_SET: assert property (@(posedge clk) disable iff (rst)
      tick_wr |=> armed); // R4

   AST_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
      (fire && !tick_wr) |=> !armed); // R4

   AST_RB_PAIR: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (rb_secs == $past(cnt_secs) && rb_ticks == $past(cnt_ticks))); // R9
endmodule

bind tod_timekeeper tod_timekeeper_chk #(.SECS_W(SECS_W), .TICKS_W(TICKS_W)) u_chk (
   .clk(clk), .rst(rst), .tick_wr(tick_wr), .fire(fire), .armed(armed),
   .cnt_secs(cnt_secs), .cnt_ticks(cnt_ticks), .ld_secs(ld_secs), .ld_ticks(ld_ticks),
   .tps(tps), .rb_secs(rb_secs), .rb_ticks(rb_ticks)
);

// File: tb/sim_tod_timekeeper.sv
module sim_tod_timekeeper;
   localparam int AW = 8;
   localparam int DW = 32;
   localparam int unsigned BASE = 32;
   localparam int DEF_T = 12;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          stb = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] data = '0;
   logic          pl = 1'b0;
   logic          pc = 1'b0;
   logic [31:0]   rs;
   logic [31:0]   rt;

   always #5 clk = ~clk;

   tod_timekeeper #(.ADDR_W(AW), .DATA_W(DW), .SECS_W(32), .TICKS_W(32),
                    .REG_BASE(BASE), .DEF_TPS(DEF_T), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst(rst), .set_stb(stb), .set_addr(addr), .set_data(data),
      .pps_local(pl), .pps_cable(pc), .rb_secs(rs), .rb_ticks(rt)
   );

   int    total = 0;
   int    bad = 0;
   bit    finished = 0;
   string cur_req = "R1";
   logic [63:0] q[$];

   task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // reference model built from the requirements
   logic [31:0] m_ss, m_st, m_tps, m_secs, m_ticks;
   logic        m_pol, m_src, m_imm, m_armed, m_fire;
   logic [1:0]  m_s1, m_s2, m_pv, m_e;
   logic [63:0] m_rb;

   always @(posedge clk) begin
      if (rst) begin
         m_ss = 0; m_st = 0; m_tps = DEF_T; m_secs = 0; m_ticks = 0;
         m_pol = 0; m_src = 0; m_imm = 0; m_armed = 0;
         m_s1 = 0; m_s2 = 0; m_pv = 0; m_rb = 0;
      end else begin
         for (int s = 0; s < 2; s++)
            m_e[s] = m_pol ? (m_s2[s] && !m_pv[s]) : (!m_s2[s] && m_pv[s]);
         m_fire = m_armed && (m_imm || m_e[m_src]);
         m_rb = {m_secs, m_ticks};
         if (m_fire) begin
            m_secs = m_ss; m_ticks = m_st;
         end else if (m_ticks >= m_tps - 32'd1) begin
            m_ticks = 0; m_secs = m_secs + 1;
         end else begin
            m_ticks = m_ticks + 1;
         end
         m_pv = m_s2; m_s2 = m_s1; m_s1 = {pc, pl};
         if (stb && addr == AW'(BASE + 1)) m_armed = 1;
         else if (m_fire) m_armed = 0;
         if (stb) begin
            if (addr == AW'(BASE + 0)) m_ss = data;
            if (addr == AW'(BASE + 1)) m_st = data;
            if (addr == AW'(BASE + 2)) begin m_pol = data[0]; m_src = data[1]; end
            if (addr == AW'(BASE + 3)) m_imm = data[0];
            if (addr == AW'(BASE + 4)) m_tps = data;
         end
      end
      q.push_back(m_rb);
   end

   // monitor: compare each readback pair against the queued expectation
   always @(negedge clk) begin
      if (q.size() > 0) begin
         logic [63:0] exp;
         exp = q.pop_front();
         check({rs, rt} == exp, cur_req, {rs, rt}, exp);
      end
   end

   task automatic wr_raw(logic [AW-1:0] a, logic [DW-1:0] v);
      @(negedge clk);
      stb = 1'b1; addr = a; data = v;
      @(negedge clk);
      stb = 1'b0;
   endtask

   task automatic wr(int idx, logic [DW-1:0] v);
      wr_raw(AW'(BASE + idx), v);
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      check(rs == 0 && rt == 0, "R1", {rs, rt}, 64'd0);
      rst = 1'b0;
      cur_req = "R2"; idle(30);
      cur_req = "R3"; wr(4, 5); idle(12);
      wr(5, 2); wr_raw(AW'(BASE - 1), 2); idle(12);
      cur_req = "R5"; wr(3, 1); wr(0, 100); wr(1, 3); idle(8);
      cur_req = "R6"; wr(3, 0); wr(2, 1); wr(0, 200); wr(1, 0); idle(6);
      pl = 1'b1; idle(8);
      cur_req = "R4"; pl = 1'b0; idle(4); pl = 1'b1; idle(6); pl = 1'b0; idle(4);
      cur_req = "R6"; wr(2, 0); wr(0, 300); wr(1, 1); pl = 1'b1; idle(6);
      pl = 1'b0; idle(8);
      cur_req = "R7"; wr(2, 3); wr(0, 400); wr(1, 2); pl = 1'b1; idle(6);
      pl = 1'b0; idle(4);
      cur_req = "R8";
      @(negedge clk) pc = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(rs != 400, "R8", {32'd0, rs}, 64'd400);
      @(posedge clk);
      @(negedge clk);
      check(rs == 400, "R8", {32'd0, rs}, 64'd400);
      idle(6); pc = 1'b0; idle(4);
      cur_req = "R10"; wr(4, 1); idle(6);
      wr(4, 0); wr(3, 1); wr(0, 9); wr(1, 32'hFFFF_FFFD); idle(6);
      wr(4, 5); wr(0, 1); wr(1, 50); idle(6);
      cur_req = "R9"; idle(10);
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #100000;
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog %s actual=running expected=done", cur_req);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule